// File: doc/BRIEF.md
# Chip-Select Override and Polarity Unit

This block produces the eight physical chip-select pins of a SPI master. In normal operation each pin follows the transfer engine: a line is driven to its active level while the engine reports busy and its one-hot select request names that line, and it rests at the inactive level otherwise. A per-line polarity byte sets which level counts as active for each line.

Software can also take a line away from the engine through an override register. Each line has an enable bit and a forced-level bit. While the enable bit is set, the pin shows the forced level. This lets firmware keep a device selected across several separate engine commands, with no dependence on the engine's own select timing. Line 7 serves an internal peripheral, so the override path never touches it.

A simple write port loads the two registers, and a combinational read port returns them. The pins are combinational outputs of the registered state and the engine inputs. A change takes effect on the pins in the same cycle the input changes, or just after the clock edge that captures a register write.

Top module: `cs_select_unit`

## Requirements
- R1: While reset is applied and after it is released, the polarity and override registers hold zero. With the engine idle, every pin is then high, which is the inactive level for polarity 0.
- R2: A write to address 0 stores wr_data_i[7:0] as the polarity byte. Bit i set to 1 makes line i active-high. Reading address 0 returns the byte in bits 7:0 and zero in bits 31:8.
- R3: A write to address 1 stores override-enable bits from wr_data_i[7:0] and forced-level bits from wr_data_i[15:8]. Reading address 1 returns exactly those 16 bits, including the levels of lines that are not enabled, with zero in bits 31:16.
- R4: A line that is not overridden is driven to its polarity bit while eng_busy_i is 1 and eng_sel_i selects that line. Otherwise it is driven to the inverse of its polarity bit.
- R5: For lines 0 to 6 with the override-enable bit set, the pin equals the forced-level bit, whatever the engine inputs and the polarity are.
- R6: Clearing a line's override-enable bit hands that line back to engine control, starting from the edge that captures the write.
- R7: Line 7 ignores its override-enable and forced-level bits and is always under engine control.
- R8: A write to any address other than 0 or 1 changes neither register. Reading any such address returns zero.
- R9: The configured line count CS_COUNT is clamped to 8. Lines at or above the effective count are held at their inactive level and ignore both the engine and the override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 4 | Register read address |
| rd_data_o | output | 32 | Register read data (combinational) |
| eng_busy_i | input | 1 | Transfer engine busy |
| eng_sel_i | input | 8 | Engine one-hot line select |
| cs_pin_o | output | 8 | Physical chip-select pins |

## Verification
A corrupted polarity or override bit appears on the affected pin in the cycle right after the write that should have set it, because the pin logic has no register of its own. The faulty value also appears on rd_data_o as soon as the bench reads that address. An error in the line-selection logic, such as a reserved or unused line that answers the override, shows up immediately during the sweep. The sweep crosses polarity, override and engine patterns, and every combination is compared on all eight pins of both a full-width and a narrowed instance.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int CS_MAX     = 8;
  localparam int REG_ADDR_W = 4;
  localparam int REG_DATA_W = 32;
  localparam logic [REG_ADDR_W-1:0] ADDR_POLARITY = 4'h0;
  localparam logic [REG_ADDR_W-1:0] ADDR_OVERRIDE = 4'h1;

  typedef struct packed {
    logic [CS_MAX-1:0] lvl;  // forced pin level, bits 15:8
    logic [CS_MAX-1:0] en;   // override enable, bits 7:0
  } ovr_t;
endpackage

// File: rtl/cs_regs.sv
module cs_regs
  import cs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic [REG_ADDR_W-1:0] wr_addr_i,
  input  logic [REG_DATA_W-1:0] wr_data_i,
  input  logic [REG_ADDR_W-1:0] rd_addr_i,
  output logic [REG_DATA_W-1:0] rd_data_o,
  output logic [CS_MAX-1:0]     pol_o,
  output ovr_t                  ovr_o
);
  localparam int OVR_W = $bits(ovr_t);

  logic [CS_MAX-1:0] pol_q;
  ovr_t              ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= '0;
      ovr_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_POLARITY) pol_q <= wr_data_i[CS_MAX-1:0];
      if (wr_addr_i == ADDR_OVERRIDE) ovr_q <= ovr_t'(wr_data_i[OVR_W-1:0]);
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      ADDR_POLARITY: rd_data_o[CS_MAX-1:0] = pol_q;
      ADDR_OVERRIDE: rd_data_o[OVR_W-1:0]  = ovr_q;
      default:       rd_data_o = '0;
    endcase
  end

  assign pol_o = pol_q;
  assign ovr_o = ovr_q;
endmodule

// File: rtl/cs_line.sv
module cs_line #(
  parameter bit USED   = 1'b1,
  parameter bit OVR_OK = 1'b1
) (
  input  logic pol_i,
  input  logic busy_i,
  input  logic sel_i,
  input  logic ovr_en_i,
  input  logic ovr_lvl_i,
  output logic pin_o
);
  logic eng_active;
  logic take_ovr;

  assign eng_active = USED && busy_i && sel_i;
  assign take_ovr   = USED && OVR_OK && ovr_en_i;

  always_comb begin
    if (take_ovr)        pin_o = ovr_lvl_i;
    else if (eng_active) pin_o = pol_i;
    else                 pin_o = ~pol_i;
  end
endmodule

// File: rtl/cs_select_unit.sv
module cs_select_unit
  import cs_pkg::*;
#(
  parameter int CS_COUNT      = 8,
  parameter int RESERVED_LINE = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic [REG_ADDR_W-1:0] wr_addr_i,
  input  logic [REG_DATA_W-1:0] wr_data_i,
  input  logic [REG_ADDR_W-1:0] rd_addr_i,
  output logic [REG_DATA_W-1:0] rd_data_o,
  input  logic                  eng_busy_i,
  input  logic [CS_MAX-1:0]     eng_sel_i,
  output logic [CS_MAX-1:0]     cs_pin_o
);
  localparam int LINES = (CS_COUNT > CS_MAX) ? CS_MAX : CS_COUNT;

  logic [CS_MAX-1:0] pol_q;
  ovr_t              ovr_q;

  cs_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .pol_o     (pol_q),
    .ovr_o     (ovr_q)
  );

  for (genvar g = 0; g < CS_MAX; g++) begin : g_line
    cs_line #(
      .USED   (g < LINES),
      .OVR_OK (g != RESERVED_LINE)
    ) u_line (
      .pol_i     (pol_q[g]),
      .busy_i    (eng_busy_i),
      .sel_i     (eng_sel_i[g]),
      .ovr_en_i  (ovr_q.en[g]),
      .ovr_lvl_i (ovr_q.lvl[g]),
      .pin_o     (cs_pin_o[g])
    );
  end
endmodule

// File: rtl/cs_select_checker.sv
module cs_select_checker
  import cs_pkg::*;
#(
  parameter int LINES         = 8,
  parameter int RESERVED_LINE = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [REG_ADDR_W-1:0] wr_addr,
  input logic [CS_MAX-1:0]     wr_byte,
  input logic                  eng_busy,
  input logic [CS_MAX-1:0]     cs_pin,
  input logic [CS_MAX-1:0]     pol_q,
  input ovr_t                  ovr_q
);
  localparam logic [CS_MAX-1:0] USED_MASK = CS_MAX'((9'h1 << LINES) - 9'h1);
  localparam logic [CS_MAX-1:0] OVR_MASK  = USED_MASK & ~CS_MAX'(9'h1 << RESERVED_LINE);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pol_q == '0 && ovr_q == '0)); // R1

  AST_POL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_POLARITY) |=> (pol_q == $past(wr_byte))); // R2

  AST_OVR_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (((cs_pin ^ ovr_q.lvl) & ovr_q.en & OVR_MASK) == '0)); // R5

  AST_IDLE_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_busy |-> (((cs_pin ^ ~pol_q) & ~(ovr_q.en & OVR_MASK)) == '0)); // R4

  AST_RESERVED_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_busy |-> (cs_pin[RESERVED_LINE] != pol_q[RESERVED_LINE])); // R7

  AST_BAD_ADDR_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != ADDR_POLARITY && wr_addr != ADDR_OVERRIDE)
      |=> ($stable(pol_q) && $stable(ovr_q))); // R8

  AST_UNUSED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (((cs_pin ^ ~pol_q) & ~USED_MASK) == '0)); // R9
endmodule

bind cs_select_unit cs_select_checker #(
  .LINES         (LINES),
  .RESERVED_LINE (RESERVED_LINE)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en_i),
  .wr_addr  (wr_addr_i),
  .wr_byte  (wr_data_i[7:0]),
  .eng_busy (eng_busy_i),
  .cs_pin   (cs_pin_o),
  .pol_q    (pol_q),
  .ovr_q    (ovr_q)
);

// File: tb/test_cs_select_unit.sv
module test_cs_select_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NARROW     = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data, rd_data_n;
  logic        busy = 1'b0;
  logic [7:0]  sel = '0;
  logic [7:0]  pins, pins_n;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cs_select_unit #(.CS_COUNT(10)) i_cs_select_unit (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .eng_busy_i(busy), .eng_sel_i(sel), .cs_pin_o(pins));

  cs_select_unit #(.CS_COUNT(NARROW)) i_cs_select_unit_n (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data_n),
    .eng_busy_i(busy), .eng_sel_i(sel), .cs_pin_o(pins_n));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [7:0] expect_pins(input int lines, input logic [7:0] pol,
      input logic [7:0] en, input logic [7:0] lvl, input logic bsy, input logic [7:0] s);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      if (i >= lines)                r[i] = ~pol[i];
      else if (en[i] && i != 7)      r[i] = lvl[i];
      else if (bsy && s[i])          r[i] = pol[i];
      else                           r[i] = ~pol[i];
    end
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] pol_set [5] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h3C};
    logic [7:0] en_set  [4] = '{8'h00, 8'hFF, 8'h0F, 8'h81};
    logic [7:0] lvl_set [3] = '{8'h00, 8'hFF, 8'h96};

    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    check("R1 pins in reset", {24'h0, pins}, 32'h0000_00FF);
    rd_addr = 4'h0; #1; check("R1 polarity reset", rd_data, 32'h0);
    rd_addr = 4'h1; #1; check("R1 override reset", rd_data, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 pins after reset", {24'h0, pins}, 32'h0000_00FF);

    // R2, R3 read back
    write_reg(4'h0, 32'hDEAD_BEA5);
    rd_addr = 4'h0; #1; check("R2 polarity readback", rd_data, 32'h0000_00A5);
    write_reg(4'h1, 32'h1234_C30F);
    rd_addr = 4'h1; #1; check("R3 override readback", rd_data, 32'h0000_C30F);

    // R8: unmapped writes and reads
    for (int a = 2; a < 16; a++) write_reg(4'(a), 32'hFFFF_FFFF);
    rd_addr = 4'h0; #1; check("R8 polarity kept", rd_data, 32'h0000_00A5);
    rd_addr = 4'h1; #1; check("R8 override kept", rd_data, 32'h0000_C30F);
    rd_addr = 4'h9; #1; check("R8 unmapped read", rd_data, 32'h0);

    // R4 / R5 / R9 sweep
    foreach (pol_set[p]) foreach (en_set[e]) foreach (lvl_set[l]) begin
      write_reg(4'h0, {24'h0, pol_set[p]});
      write_reg(4'h1, {16'h0, lvl_set[l], en_set[e]});
      for (int b = 0; b < 2; b++) begin
        for (int s = 0; s <= 8; s++) begin
          @(negedge clk);
          busy = b[0];
          sel  = (s == 8) ? 8'h00 : 8'(1 << s);
          #1;
          check((en_set[e] & 8'h7F) != 0 ? "R5 override sweep" : "R4 engine sweep",
                {24'h0, pins},
                {24'h0, expect_pins(8, pol_set[p], en_set[e], lvl_set[l], busy, sel)});
          check("R9 narrow instance", {24'h0, pins_n},
                {24'h0, expect_pins(NARROW, pol_set[p], en_set[e], lvl_set[l], busy, sel)});
        end
      end
    end

    // R6: release override returns line to engine
    @(negedge clk); busy = 1'b0; sel = 8'h00;
    write_reg(4'h0, 32'h0);
    write_reg(4'h1, 32'h0000_FF04);
    @(negedge clk); busy = 1'b1; sel = 8'h04; #1;
    check("R6 line 2 forced high", {31'h0, pins[2]}, 32'h1);
    write_reg(4'h1, 32'h0000_FF00);
    #1;
    check("R6 line 2 back to engine", {31'h0, pins[2]}, 32'h0);
    rd_addr = 4'h1; #1; check("R3 level kept when disabled", rd_data, 32'h0000_FF00);

    // R7: reserved line ignores override
    @(negedge clk); busy = 1'b0; sel = 8'h00;
    write_reg(4'h1, 32'h0000_0080);
    #1;
    check("R7 line 7 idle stays inactive", {31'h0, pins[7]}, 32'h1);
    @(negedge clk); busy = 1'b1; sel = 8'h80; #1;
    check("R7 line 7 follows engine", {31'h0, pins[7]}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule